// File: doc/BRIEF.md
# Sector Fill Prefetch Sequencer

This block orders the line fills an instruction cache asks for when its lines are grouped in pairs, two lines to a sector. When a miss is accepted, the block first requests one 32-byte burst read for the line that missed. If the miss replaces a whole sector and the missing line is the lower half of that sector, the block then requests a second burst for the upper line. This second burst is a forward-only prefetch. A miss that replaces only one line, or that falls in the upper half of a sector, produces a single burst. When the last burst finishes, the block pulses a fill-complete output.

Addresses pass through the block as line numbers. A line number is the byte address divided by the 32-byte line size. Bit 0 of a line number chooses the half of the sector. Between the two bursts the block either goes straight on or waits. It goes straight to the second burst only when the bus reported next-address readiness during the first burst and nothing else holds it back. It waits in a gap while higher-priority data traffic is pending or while the bus is held or backed off. While the bus is held or backed off, the block also withdraws any burst request it has outstanding.

Top module: `sector_fill_seq`

## Requirements
- R1: After reset, `burst_req` and `fill_done` are 0, and the block is ready to accept a miss.
- R2: In the cycle after an idle block samples `miss_valid`, `burst_req` is 1 and `burst_line` equals the sampled `miss_line`. The address stays unchanged until that burst completes.
- R3: A miss with `miss_sector` = 0 produces exactly one burst. No second request follows its `burst_done`.
- R4: A miss with `miss_sector` = 1 and `miss_line` bit 0 = 0 produces a second burst after the first. The second burst uses the same line number with bit 0 set to 1.
- R5: A miss with `miss_sector` = 1 and `miss_line` bit 0 = 1 produces only one burst. There is no prefetch toward the lower line.
- R6: Suppose `na` is seen high in any cycle of the first burst, up to and including its `burst_done` cycle. If `hp_data`, `ahold` and `boff` are all low in the `burst_done` cycle, the second request is raised in the very next cycle.
- R7: If `na` is never seen high during the first burst, `burst_req` is 0 for at least one cycle between the two bursts.
- R8: Suppose that at the end of the first burst `hp_data`, `ahold` or `boff` is high, or that back-to-back is not allowed. The gap then lasts while any of these three inputs is high. The second request appears in the cycle after the first clock edge at which all three are low.
- R9: While a burst is outstanding, `burst_req` is 0 in every cycle in which `ahold` or `boff` is 1, and `burst_line` is held.
- R10: `fill_done` is a single-cycle pulse. It is raised in the cycle after the final `burst_done` of a fill.
- R11: `miss_valid` is ignored from acceptance until the block is idle again, including the `fill_done` cycle. It changes neither the outstanding address nor the number of bursts.
- R12: `burst_done` sampled while no burst is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request present |
| miss_line | input | LINE_W | Line number of the missing line; bit 0 selects sector half |
| miss_sector | input | 1 | 1 = whole sector is replaced |
| burst_done | input | 1 | Current burst read has completed |
| na | input | 1 | Bus ready for the next address |
| ahold | input | 1 | Bus address hold |
| boff | input | 1 | Bus back-off |
| hp_data | input | 1 | Higher-priority data read or write pending |
| burst_req | output | 1 | Request a 32-byte burst read |
| burst_line | output | LINE_W | Line number of the requested burst |
| fill_done | output | 1 | One-cycle pulse when the fill is complete |

## Verification
The fill sequence is exercised under several distinct stimulus patterns. One is a single-line replacement. Another is a sector replacement of the lower line with next-address readiness seen, and a third is the same case without it. A fourth is a sector replacement of the upper line. Together these separate the one-burst paths from the two-burst paths, and the back-to-back case from the gapped case. Further tests hold the gap open with priority traffic, address hold and back-off in turn, and they stall an outstanding request. These show that the release cycle and the held address are exact. Stray misses and stray completions are then applied while the block is busy or idle, to confirm they leave the sequence untouched.

// File: rtl/sector_fill_seq.sv
module sector_fill_seq #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  localparam int LINE_BITS = $clog2(LINE_BYTES),
  localparam int LINE_W    = ADDR_W - LINE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [LINE_W-1:0] miss_line,
  input  logic              miss_sector,
  input  logic              burst_done,
  input  logic              na,
  input  logic              ahold,
  input  logic              boff,
  input  logic              hp_data,
  output logic              burst_req,
  output logic [LINE_W-1:0] burst_line,
  output logic              fill_done
);

  typedef enum logic [2:0] {S_IDLE, S_FIRST, S_GAP, S_SECOND, S_DONE} state_t;

  state_t            state;
  logic [LINE_W-1:1] sect_q;
  logic              half_q;
  logic              want2_q;
  logic              na_seen_q;

  wire stall    = ahold | boff;
  wire hold_gap = stall | hp_data;
  wire chain    = (na_seen_q | na) & ~hold_gap;

  assign burst_req  = ((state == S_FIRST) || (state == S_SECOND)) && !stall;
  assign burst_line = {sect_q, (state == S_SECOND) ? 1'b1 : half_q};
  assign fill_done  = (state == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      sect_q    <= '0;
      half_q    <= 1'b0;
      want2_q   <= 1'b0;
      na_seen_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (miss_valid) begin
          sect_q    <= miss_line[LINE_W-1:1];
          half_q    <= miss_line[0];
          want2_q   <= miss_sector & ~miss_line[0];
          na_seen_q <= 1'b0;
          state     <= S_FIRST;
        end
        S_FIRST: begin
          na_seen_q <= na_seen_q | na;
          if (burst_done) begin
            if (!want2_q)   state <= S_DONE;
            else if (chain) state <= S_SECOND;
            else            state <= S_GAP;
          end
        end
        S_GAP:    if (!hold_gap) state <= S_SECOND;
        S_SECOND: if (burst_done) state <= S_DONE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> !fill_done);

  // R10
  done_follows_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |-> $past(burst_done));

  // R3
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> !burst_req);

  // R9
  addr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_req && $past(burst_req) && !$past(burst_done)) |-> $stable(burst_line));

  // R4
  forward_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SECOND) |-> (half_q == 1'b0));

endmodule

// File: tb/sector_fill_seq_test.sv
module sector_fill_seq_test;
  localparam int LW = 27;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          miss_valid = 1'b0;
  logic [LW-1:0] miss_line = '0;
  logic          miss_sector = 1'b0;
  logic          burst_done = 1'b0;
  logic          na = 1'b0;
  logic          ahold = 1'b0;
  logic          boff = 1'b0;
  logic          hp_data = 1'b0;
  logic          burst_req;
  logic [LW-1:0] burst_line;
  logic          fill_done;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  sector_fill_seq uut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_line(miss_line),
    .miss_sector(miss_sector), .burst_done(burst_done), .na(na), .ahold(ahold),
    .boff(boff), .hp_data(hp_data), .burst_req(burst_req),
    .burst_line(burst_line), .fill_done(fill_done)
  );

  always #4 clk = ~clk;

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic start(input logic [LW-1:0] line, input logic sector);
    miss_valid = 1'b1; miss_line = line; miss_sector = sector;
    cyc();
    miss_valid = 1'b0;
  endtask

  task automatic finish_burst();
    burst_done = 1'b1;
    cyc();
    burst_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 burst_req", burst_req, 0);
    chk("R1 fill_done", fill_done, 0);
  endtask

  task automatic t_single();
    start(27'h12345B, 1'b0);
    chk("R2 req", burst_req, 1);
    chk("R2 line", burst_line, 27'h12345B);
    cyc(); cyc();
    chk("R2 line held", burst_line, 27'h12345B);
    finish_burst();
    chk("R3 done", fill_done, 1);
    chk("R3 no req", burst_req, 0);
    cyc();
    chk("R10 pulse", fill_done, 0);
    chk("R3 no second", burst_req, 0);
  endtask

  task automatic t_b2b();
    start(27'h82, 1'b1);
    chk("R2 line", burst_line, 27'h82);
    na = 1'b1; cyc(); na = 1'b0;
    finish_burst();
    chk("R6 b2b req", burst_req, 1);
    chk("R4 line", burst_line, 27'h83);
    finish_burst();
    chk("R10 done", fill_done, 1);
    cyc();
    chk("R10 pulse", fill_done, 0);
  endtask

  task automatic t_gap();
    start(27'h100, 1'b1);
    finish_burst();
    chk("R7 gap", burst_req, 0);
    hp_data = 1'b1; cyc();
    chk("R8 hp gap", burst_req, 0);
    hp_data = 1'b0; ahold = 1'b1; cyc();
    chk("R8 ahold gap", burst_req, 0);
    ahold = 1'b0; boff = 1'b1; cyc();
    chk("R8 boff gap", burst_req, 0);
    boff = 1'b0; cyc();
    chk("R8 released", burst_req, 1);
    chk("R4 line", burst_line, 27'h101);
    finish_burst();
    chk("R10 done", fill_done, 1);
    cyc();
  endtask

  task automatic t_na_but_hp();
    start(27'h200, 1'b1);
    na = 1'b1; hp_data = 1'b1;
    finish_burst();
    na = 1'b0;
    chk("R8 hp blocks chain", burst_req, 0);
    hp_data = 1'b0; cyc();
    chk("R8 second", burst_req, 1);
    chk("R4 line", burst_line, 27'h201);
    finish_burst();
    cyc();
  endtask

  task automatic t_upper();
    start(27'h301, 1'b1);
    chk("R5 line", burst_line, 27'h301);
    na = 1'b1;
    finish_burst();
    na = 1'b0;
    chk("R5 done", fill_done, 1);
    chk("R5 no prefetch", burst_req, 0);
    cyc();
    chk("R5 still none", burst_req, 0);
  endtask

  task automatic t_stall();
    start(27'h402, 1'b1);
    ahold = 1'b1; cyc();
    chk("R9 ahold drop", burst_req, 0);
    ahold = 1'b0; boff = 1'b1; cyc();
    chk("R9 boff drop", burst_req, 0);
    boff = 1'b0; cyc();
    chk("R9 back", burst_req, 1);
    chk("R9 line held", burst_line, 27'h402);
    na = 1'b1; finish_burst(); na = 1'b0;
    boff = 1'b1; cyc();
    chk("R9 second drop", burst_req, 0);
    boff = 1'b0; cyc();
    chk("R9 second line", burst_line, 27'h403);
    finish_burst();
    cyc();
  endtask

  task automatic t_busy_miss();
    start(27'h500, 1'b0);
    miss_valid = 1'b1; miss_line = 27'h777; miss_sector = 1'b1;
    cyc();
    chk("R11 line kept", burst_line, 27'h500);
    finish_burst();
    chk("R11 done", fill_done, 1);
    miss_valid = 1'b1;
    cyc();
    miss_valid = 1'b0;
    chk("R11 no req", burst_req, 0);
    cyc();
    chk("R11 still idle", burst_req, 0);
  endtask

  task automatic t_idle_done();
    burst_done = 1'b1; cyc(); burst_done = 1'b0;
    chk("R12 no done", fill_done, 0);
    chk("R12 no req", burst_req, 0);
    start(27'h600, 1'b0);
    chk("R12 normal", burst_line, 27'h600);
    finish_burst();
    chk("R12 fill", fill_done, 1);
    cyc();
  endtask

  task automatic report();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    cyc(); cyc();
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_b2b();
    t_gap();
    t_na_but_hp();
    t_upper();
    t_stall();
    t_busy_miss();
    t_idle_done();
    report();
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    report();
  end
endmodule